// File: doc/BRIEF.md
# Dual-Lane Data Register File with Pointer-Selected Broadcast Loads

This block holds the data registers of a core with two processing lanes, a primary lane and a secondary lane, each with its own bank of registers. Every cycle it can take one transfer from each of two data buses, called bus A and bus B. A transfer carries a kind code, a register number, a bit that names the lane of the target register, the tag of the address pointer that produced its address, and the data words. Two reads, each returning the same-numbered register from both lanes, are available combinationally.

Broadcast loading is enabled per bus by one mode bit each. Bus A broadcasts only when its transfer was addressed through pointer 1. Bus B broadcasts only when its transfer was addressed through pointer 9. A broadcast load writes the same word into the named register and into the register with the same number in the other lane. This happens whether or not SIMD mode is on. With SIMD on, a data load that does not broadcast fills the other lane from the transfer's second data word. Loads into other register classes and stores never write this file. The block also gives one pointer-step strobe per transfer. This tells the address logic that one post-modify is due, however many registers the transfer wrote.

Top module: `dlrf_top`

## Requirements
- R1: While rst_n is low, all registers in both lanes are cleared at each rising edge. After release, every read returns zero until a write takes place.
- R2: A valid transfer of kind 0 (data register load) writes its data word into register `idx` at the next rising edge. The lane is the primary lane when the lane bit is 0 and the secondary lane when it is 1. Reads are combinational, with lane 0 on the `_pri` output and lane 1 on the `_sec` output.
- R3: When `bcast_a_en` is 1 and `a_ptr` equals 1, a kind-0 transfer on bus A also writes the identical data word into the same-numbered register of the other lane. Bus B behaves the same way with `bcast_b_en` and a `b_ptr` of 9.
- R4: Broadcast needs both the enable bit and the pointer tag of its own bus. Bus A with tag 9, bus B with tag 1, any other tag, or a cleared enable leaves the other lane untouched while SIMD is off.
- R5: A transfer of kind 1 (load into a non-data register), kind 2 (store) or kind 3 (idle) writes no register in either lane. This holds even when the enable and tag would select broadcast.
- R6: With `simd_en` at 1, a kind-0 transfer that does not broadcast writes its second word (`_data_y`) into the same-numbered register of the other lane. A broadcast transfer writes its first word into both lanes whatever the state of `simd_en`.
- R7: In a dual transfer, each bus decides broadcast from its own enable and tag, independently of the other bus.
- R8: When the two buses write the same register in the same lane in one cycle, whether as the named register or as a copy, bus B's word is stored and `conflict` is 1 in that cycle. In every other cycle `conflict` is 0.
- R9: `a_step` and `b_step` are 1 exactly in the cycles where their bus presents a valid transfer of any kind. This is one pulse per transfer, and a broadcast does not add a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bcast_a_en | input | 1 | Broadcast enable for bus A loads through pointer 1 |
| bcast_b_en | input | 1 | Broadcast enable for bus B loads through pointer 9 |
| simd_en | input | 1 | SIMD mode |
| a_valid | input | 1 | Bus A transfer present |
| a_op | input | 2 | Bus A kind: 0 data load, 1 other-register load, 2 store, 3 idle |
| a_idx | input | 4 | Bus A register number |
| a_lane | input | 1 | Bus A named lane: 0 primary, 1 secondary |
| a_ptr | input | 4 | Bus A address pointer tag |
| a_data | input | 32 | Bus A data word |
| a_data_y | input | 32 | Bus A second word for the other lane in SIMD mode |
| b_valid | input | 1 | Bus B transfer present |
| b_op | input | 2 | Bus B kind, encoded as for bus A |
| b_idx | input | 4 | Bus B register number |
| b_lane | input | 1 | Bus B named lane |
| b_ptr | input | 4 | Bus B address pointer tag |
| b_data | input | 32 | Bus B data word |
| b_data_y | input | 32 | Bus B second word |
| rd0_idx | input | 4 | Read port 0 register number |
| rd1_idx | input | 4 | Read port 1 register number |
| rd0_pri | output | 32 | Read port 0, primary lane |
| rd0_sec | output | 32 | Read port 0, secondary lane |
| rd1_pri | output | 32 | Read port 1, primary lane |
| rd1_sec | output | 32 | Read port 1, secondary lane |
| conflict | output | 1 | Both buses write one register this cycle |
| a_step | output | 1 | One pointer post-modify due for bus A |
| b_step | output | 1 | One pointer post-modify due for bus B |

## Verification
The assertions assume that all mode and transfer inputs are known values whenever reset is released. They also assume that reset is held low from time zero until the first release, so the clear check sees a real rising edge of `rst_n`. The bench drives every input from its declaration onward, keeps reset low for several cycles, and changes inputs only just after a falling edge, so the sampled values are always settled. Random stimulus biases the pointer tags toward 1 and 9 and reuses a small range of register numbers, so that broadcasts, refused broadcasts and same-register collisions all happen often.

// File: rtl/dlrf_pkg.sv
// Package: shared types for the dual-lane register file.
// Assumes a two-bit transfer kind code supplied by the issuing logic.
package dlrf_pkg;

    typedef enum logic [1:0] {
        XF_LOAD_DATA = 2'd0,
        XF_LOAD_SYS  = 2'd1,
        XF_STORE     = 2'd2,
        XF_IDLE      = 2'd3
    } xfer_kind_e;

    localparam int LANES = 2;

endpackage

// File: rtl/dlrf_route.sv
// Module: dlrf_route
// Turns one bus transfer into per-lane write strobes and data words.
// It decides whether the transfer writes the named lane, and whether the
// other lane receives a broadcast copy or a SIMD second word.
// Assumes the pointer tag arrives with the transfer, already decoded by
// the address logic.
module dlrf_route
    import dlrf_pkg::*;
#(
    parameter int DW     = 32,
    parameter int PW     = 4,
    parameter int BC_PTR = 1
) (
    input  logic          valid,
    input  logic [1:0]    op,
    input  logic          lane,
    input  logic [PW-1:0] ptr,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] data_y,
    input  logic          bc_en,
    input  logic          simd_en,
    output logic [LANES-1:0] lane_we,
    output logic [DW-1:0] lane_wd [LANES],
    output logic          step
);

    localparam logic [PW-1:0] BC_TAG = PW'(BC_PTR);

    logic          load_ok;
    logic          bcast_hit;
    logic          imp_we;
    logic [DW-1:0] imp_wd;

    // Classify the transfer and pick the word for the implicit lane.
    always_comb begin
        load_ok   = valid && (op == XF_LOAD_DATA);
        bcast_hit = load_ok && bc_en && (ptr == BC_TAG);
        imp_we    = load_ok && (bcast_hit || simd_en);
        imp_wd    = bcast_hit ? data : data_y;
    end

    // Steer explicit and implicit writes to the lane each belongs to.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if (lane == l[0]) begin
                lane_we[l] = load_ok;
                lane_wd[l] = data;
            end else begin
                lane_we[l] = imp_we;
                lane_wd[l] = imp_wd;
            end
        end
    end

    // Post-modify strobe: exactly one per transfer.
    assign step = valid;

endmodule

// File: rtl/dlrf_bank.sv
// Module: dlrf_bank
// One lane's bank of data registers with NWR write ports and NRD
// combinational read ports. When two write ports hit the same register in
// one cycle, the higher-numbered port wins.
// Assumes NREG is a power of two so that every index is in range.
module dlrf_bank #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    parameter int NWR  = 2,
    parameter int NRD  = 2,
    localparam int IW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NWR-1:0] we,
    input  logic [IW-1:0]  widx  [NWR],
    input  logic [DW-1:0]  wdata [NWR],
    input  logic [IW-1:0]  ridx  [NRD],
    output logic [DW-1:0]  rdata [NRD]
);

    logic [DW-1:0] regs [NREG];

    // Clear on reset, else apply the write ports in order (later wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                regs[r] <= '0;
            end
        end else begin
            for (int p = 0; p < NWR; p++) begin
                if (we[p]) begin
                    regs[widx[p]] <= wdata[p];
                end
            end
        end
    end

    // Combinational read ports.
    for (genvar q = 0; q < NRD; q++) begin : g_rd
        assign rdata[q] = regs[ridx[q]];
    end

endmodule

// File: rtl/dlrf_clash.sv
// Module: dlrf_clash
// Flags a cycle in which both buses write the same register of the same
// lane. This covers broadcast copies as well as named targets.
// Assumes each bus writes a single register number in every lane it touches.
module dlrf_clash
    import dlrf_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [LANES-1:0] we_a,
    input  logic [LANES-1:0] we_b,
    input  logic [IW-1:0]    idx_a,
    input  logic [IW-1:0]    idx_b,
    output logic             clash
);

    // Same register number and a common lane written by both buses.
    always_comb begin
        clash = (idx_a == idx_b) && ((we_a & we_b) != '0);
    end

endmodule

// File: rtl/dlrf_top.sv
// Module: dlrf_top
// Dual-lane data register file with two load buses and per-pointer
// broadcast. Bus A broadcasts through pointer tag BC_PTR_A and bus B
// through BC_PTR_B, each under its own enable, independent of SIMD mode.
// Bus B has write priority over bus A.
// Assumes transfer inputs are stable around the rising clock edge.
module dlrf_top
    import dlrf_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NREG     = 16,
    parameter int PW       = 4,
    parameter int BC_PTR_A = 1,
    parameter int BC_PTR_B = 9,
    localparam int IW      = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bcast_a_en,
    input  logic          bcast_b_en,
    input  logic          simd_en,
    input  logic          a_valid,
    input  logic [1:0]    a_op,
    input  logic [IW-1:0] a_idx,
    input  logic          a_lane,
    input  logic [PW-1:0] a_ptr,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] a_data_y,
    input  logic          b_valid,
    input  logic [1:0]    b_op,
    input  logic [IW-1:0] b_idx,
    input  logic          b_lane,
    input  logic [PW-1:0] b_ptr,
    input  logic [DW-1:0] b_data,
    input  logic [DW-1:0] b_data_y,
    input  logic [IW-1:0] rd0_idx,
    input  logic [IW-1:0] rd1_idx,
    output logic [DW-1:0] rd0_pri,
    output logic [DW-1:0] rd0_sec,
    output logic [DW-1:0] rd1_pri,
    output logic [DW-1:0] rd1_sec,
    output logic          conflict,
    output logic          a_step,
    output logic          b_step
);

    localparam int NBUS = 2;
    localparam int NRD  = 2;

    // Per-bus views of the transfer inputs.
    logic          bus_valid [NBUS];
    logic [1:0]    bus_op    [NBUS];
    logic          bus_lane  [NBUS];
    logic [PW-1:0] bus_ptr   [NBUS];
    logic [DW-1:0] bus_data  [NBUS];
    logic [DW-1:0] bus_data_y[NBUS];
    logic          bus_en    [NBUS];
    logic [IW-1:0] bus_idx   [NBUS];
    logic          bus_step  [NBUS];

    // Router outputs, indexed [bus] and [bus][lane].
    logic [LANES-1:0] lane_we [NBUS];
    logic [DW-1:0]    lane_wd [NBUS][LANES];

    // Bank inputs, indexed [lane] and [lane][bus].
    logic [NBUS-1:0]  bank_we  [LANES];
    logic [DW-1:0]    bank_wd  [LANES][NBUS];
    logic [DW-1:0]    bank_rd  [LANES][NRD];
    logic [IW-1:0]    rd_idx   [NRD];

    // Gather the two buses into indexable form.
    always_comb begin
        bus_valid[0]  = a_valid;    bus_valid[1]  = b_valid;
        bus_op[0]     = a_op;       bus_op[1]     = b_op;
        bus_lane[0]   = a_lane;     bus_lane[1]   = b_lane;
        bus_ptr[0]    = a_ptr;      bus_ptr[1]    = b_ptr;
        bus_data[0]   = a_data;     bus_data[1]   = b_data;
        bus_data_y[0] = a_data_y;   bus_data_y[1] = b_data_y;
        bus_en[0]     = bcast_a_en; bus_en[1]     = bcast_b_en;
        bus_idx[0]    = a_idx;      bus_idx[1]    = b_idx;
        rd_idx[0]     = rd0_idx;    rd_idx[1]     = rd1_idx;
    end

    // One router per bus, each with its own broadcast pointer tag.
    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        localparam int TAG = (b == 0) ? BC_PTR_A : BC_PTR_B;
        dlrf_route #(
            .DW     (DW),
            .PW     (PW),
            .BC_PTR (TAG)
        ) u_route (
            .valid   (bus_valid[b]),
            .op      (bus_op[b]),
            .lane    (bus_lane[b]),
            .ptr     (bus_ptr[b]),
            .data    (bus_data[b]),
            .data_y  (bus_data_y[b]),
            .bc_en   (bus_en[b]),
            .simd_en (simd_en),
            .lane_we (lane_we[b]),
            .lane_wd (lane_wd[b]),
            .step    (bus_step[b])
        );
    end

    // Transpose router outputs into per-lane write ports (bus B last).
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            for (int b = 0; b < NBUS; b++) begin
                bank_we[l][b] = lane_we[b][l];
                bank_wd[l][b] = lane_wd[b][l];
            end
        end
    end

    // One register bank per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dlrf_bank #(
            .DW   (DW),
            .NREG (NREG),
            .NWR  (NBUS),
            .NRD  (NRD)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[l]),
            .widx  (bus_idx),
            .wdata (bank_wd[l]),
            .ridx  (rd_idx),
            .rdata (bank_rd[l])
        );
    end

    dlrf_clash #(
        .IW (IW)
    ) u_clash (
        .we_a  (lane_we[0]),
        .we_b  (lane_we[1]),
        .idx_a (a_idx),
        .idx_b (b_idx),
        .clash (conflict)
    );

    // Drive read outputs and step strobes.
    assign rd0_pri = bank_rd[0][0];
    assign rd0_sec = bank_rd[1][0];
    assign rd1_pri = bank_rd[0][1];
    assign rd1_sec = bank_rd[1][1];
    assign a_step  = bus_step[0];
    assign b_step  = bus_step[1];

endmodule

// File: rtl/dlrf_checker.sv
// Module: dlrf_checker
// Property checks for dlrf_top, attached by bind. It relates the transfer
// ports to the router strobes, the read outputs and the conflict flag.
// Assumes reset is held low from time zero.
module dlrf_checker #(
    parameter int DW       = 32,
    parameter int IW       = 4,
    parameter int PW       = 4,
    parameter int BC_PTR_A = 1,
    parameter int BC_PTR_B = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bcast_a_en,
    input logic          bcast_b_en,
    input logic          simd_en,
    input logic          a_valid,
    input logic [1:0]    a_op,
    input logic [IW-1:0] a_idx,
    input logic          a_lane,
    input logic [PW-1:0] a_ptr,
    input logic [DW-1:0] a_data,
    input logic          b_valid,
    input logic [1:0]    b_op,
    input logic [IW-1:0] b_idx,
    input logic [PW-1:0] b_ptr,
    input logic [DW-1:0] b_data,
    input logic [DW-1:0] rd0_pri,
    input logic [DW-1:0] rd0_sec,
    input logic [DW-1:0] rd1_pri,
    input logic [DW-1:0] rd1_sec,
    input logic          conflict,
    input logic [1:0]    we_a,
    input logic [1:0]    we_b,
    input logic [DW-1:0] wd_a0,
    input logic [DW-1:0] wd_a1,
    input logic [DW-1:0] wd_b0,
    input logic [DW-1:0] wd_b1
);

    localparam logic [PW-1:0] TAG_A = PW'(BC_PTR_A);
    localparam logic [PW-1:0] TAG_B = PW'(BC_PTR_B);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd0_pri == '0 && rd0_sec == '0 && rd1_pri == '0 && rd1_sec == '0)); // R1

    AST_BCAST_A_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_op == 2'd0 && bcast_a_en && a_ptr == TAG_A)
        |-> (we_a == 2'b11 && wd_a0 == a_data && wd_a1 == a_data)); // R3

    AST_BCAST_B_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_op == 2'd0 && bcast_b_en && b_ptr == TAG_B)
        |-> (we_b == 2'b11 && wd_b0 == b_data && wd_b1 == b_data)); // R3

    AST_NO_IMPLICIT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_op == 2'd0 && !simd_en && !(bcast_a_en && a_ptr == TAG_A))
        |-> ($countones(we_a) == 1 && we_a[a_lane])); // R4

    AST_NON_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_valid && a_op != 2'd0) || !a_valid) |-> (we_a == 2'b00)); // R5

    AST_NON_DATA_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_valid && b_op != 2'd0) || !b_valid) |-> (we_b == 2'b00)); // R5

    AST_CONFLICT_SAME_REG: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (a_valid && b_valid && a_idx == b_idx)); // R8

endmodule

bind dlrf_top dlrf_checker #(
    .DW       (DW),
    .IW       (IW),
    .PW       (PW),
    .BC_PTR_A (BC_PTR_A),
    .BC_PTR_B (BC_PTR_B)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bcast_a_en (bcast_a_en),
    .bcast_b_en (bcast_b_en),
    .simd_en    (simd_en),
    .a_valid    (a_valid),
    .a_op       (a_op),
    .a_idx      (a_idx),
    .a_lane     (a_lane),
    .a_ptr      (a_ptr),
    .a_data     (a_data),
    .b_valid    (b_valid),
    .b_op       (b_op),
    .b_idx      (b_idx),
    .b_ptr      (b_ptr),
    .b_data     (b_data),
    .rd0_pri    (rd0_pri),
    .rd0_sec    (rd0_sec),
    .rd1_pri    (rd1_pri),
    .rd1_sec    (rd1_sec),
    .conflict   (conflict),
    .we_a       (lane_we[0]),
    .we_b       (lane_we[1]),
    .wd_a0      (lane_wd[0][0]),
    .wd_a1      (lane_wd[0][1]),
    .wd_b0      (lane_wd[1][0]),
    .wd_b1      (lane_wd[1][1])
);

// File: tb/dlrf_top_test.sv
// Bench: dlrf_top_test
// Behavioural model of both banks, advanced at every rising edge and
// compared against every register after every cycle.
module dlrf_top_test;

    localparam int CLK_PERIOD = 20;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bcast_a_en = 1'b0, bcast_b_en = 1'b0, simd_en = 1'b0;
    logic        a_valid = 1'b0, b_valid = 1'b0;
    logic [1:0]  a_op = 2'd3, b_op = 2'd3;
    logic [3:0]  a_idx = '0, b_idx = '0, a_ptr = '0, b_ptr = '0;
    logic        a_lane = 1'b0, b_lane = 1'b0;
    logic [31:0] a_data = '0, a_data_y = '0, b_data = '0, b_data_y = '0;
    logic [3:0]  rd0_idx = '0, rd1_idx = '0;
    logic [31:0] rd0_pri, rd0_sec, rd1_pri, rd1_sec;
    logic        conflict, a_step, b_step;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_pri [16];
    logic [31:0] m_sec [16];

    dlrf_top uut (
        .clk(clk), .rst_n(rst_n),
        .bcast_a_en(bcast_a_en), .bcast_b_en(bcast_b_en), .simd_en(simd_en),
        .a_valid(a_valid), .a_op(a_op), .a_idx(a_idx), .a_lane(a_lane),
        .a_ptr(a_ptr), .a_data(a_data), .a_data_y(a_data_y),
        .b_valid(b_valid), .b_op(b_op), .b_idx(b_idx), .b_lane(b_lane),
        .b_ptr(b_ptr), .b_data(b_data), .b_data_y(b_data_y),
        .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
        .rd0_pri(rd0_pri), .rd0_sec(rd0_sec), .rd1_pri(rd1_pri), .rd1_sec(rd1_sec),
        .conflict(conflict), .a_step(a_step), .b_step(b_step)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Which lanes a transfer writes: explicit and implicit, plus broadcast.
    task automatic decide(input logic v, input logic [1:0] op, input logic [3:0] ptr,
                          input int tag, input logic en,
                          output bit ex, output bit im, output bit bc);
        ex = v && op == 2'd0;
        bc = ex && en && ptr == tag[3:0];
        im = ex && (bc || simd_en);
    endtask

    task automatic model_write(input bit lane, input logic [3:0] idx, input logic [31:0] d);
        if (lane) m_sec[idx] = d;
        else      m_pri[idx] = d;
    endtask

    // Compare every register of both lanes through the two read ports.
    task automatic scan(input string tag);
        bit bad = 0;
        checks++;
        for (int i = 0; i < 8; i++) begin
            rd0_idx = 4'(i);
            rd1_idx = 4'(i + 8);
            #1;
            if (!bad && (rd0_pri !== m_pri[i] || rd0_sec !== m_sec[i])) begin
                bad = 1;
                $display("FAIL %s reg %0d: got pri %h sec %h expected pri %h sec %h",
                         tag, i, rd0_pri, rd0_sec, m_pri[i], m_sec[i]);
            end
            if (!bad && (rd1_pri !== m_pri[i+8] || rd1_sec !== m_sec[i+8])) begin
                bad = 1;
                $display("FAIL %s reg %0d: got pri %h sec %h expected pri %h sec %h",
                         tag, i + 8, rd1_pri, rd1_sec, m_pri[i+8], m_sec[i+8]);
            end
        end
        if (bad) fails++;
    endtask

    // One cycle: inputs already set after a falling edge.
    task automatic tick(input string tag);
        bit aex, aim, abc, bex, bim, bbc, exp_conf;
        #1;
        decide(a_valid, a_op, a_ptr, 1, bcast_a_en, aex, aim, abc);
        decide(b_valid, b_op, b_ptr, 9, bcast_b_en, bex, bim, bbc);
        exp_conf = (a_idx == b_idx) &&
                   ((aex && bex && a_lane == b_lane) || (aex && bim && a_lane != b_lane) ||
                    (aim && bex && a_lane != b_lane) || (aim && bim && a_lane == b_lane));
        checks++;
        if (conflict !== exp_conf) begin
            fails++;
            $display("FAIL R8 (%s) conflict: got %b expected %b", tag, conflict, exp_conf);
        end
        checks++;
        if (a_step !== a_valid || b_step !== b_valid) begin
            fails++;
            $display("FAIL R9 (%s) steps: got %b%b expected %b%b", tag, a_step, b_step, a_valid, b_valid);
        end
        @(posedge clk);
        if (aex) model_write(a_lane, a_idx, a_data);
        if (aim) model_write(!a_lane, a_idx, abc ? a_data : a_data_y);
        if (bex) model_write(b_lane, b_idx, b_data);
        if (bim) model_write(!b_lane, b_idx, bbc ? b_data : b_data_y);
        @(negedge clk);
        scan(tag);
    endtask

    task automatic idle_all();
        a_valid = 0; b_valid = 0; a_op = 2'd3; b_op = 2'd3;
        bcast_a_en = 0; bcast_b_en = 0; simd_en = 0;
    endtask

    task automatic set_a(input logic [1:0] op, input logic [3:0] idx, input logic lane,
                         input logic [3:0] ptr, input logic [31:0] d, input logic [31:0] dy);
        a_valid = 1; a_op = op; a_idx = idx; a_lane = lane; a_ptr = ptr; a_data = d; a_data_y = dy;
    endtask

    task automatic set_b(input logic [1:0] op, input logic [3:0] idx, input logic lane,
                         input logic [3:0] ptr, input logic [31:0] d, input logic [31:0] dy);
        b_valid = 1; b_op = op; b_idx = idx; b_lane = lane; b_ptr = ptr; b_data = d; b_data_y = dy;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_pri[i] = '0; m_sec[i] = '0; end
        // Preload garbage writes during reset: they must be cleared.
        set_a(2'd0, 4'd2, 1'b0, 4'd1, 32'hDEAD0001, 32'hDEAD0002);
        repeat (3) @(posedge clk);
        idle_all();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        scan("R1 after reset");

        // R2: plain loads to either lane, no broadcast.
        set_a(2'd0, 4'd3, 1'b0, 4'd0, 32'h1111_0003, 32'hFFFF_0000);
        set_b(2'd0, 4'd5, 1'b1, 4'd2, 32'h2222_0005, 32'hFFFF_0001);
        tick("R2 plain loads");

        // R3: broadcast through the matching pointers.
        idle_all(); bcast_a_en = 1;
        set_a(2'd0, 4'd7, 1'b0, 4'd1, 32'hA5A5_0007, 32'h0);
        tick("R3 bus A broadcast");
        idle_all(); bcast_b_en = 1;
        set_b(2'd0, 4'd10, 1'b1, 4'd9, 32'h5A5A_000A, 32'h0);
        tick("R3 bus B broadcast from secondary");

        // R4: wrong tag or disabled enable gives no copy.
        idle_all(); bcast_a_en = 1; bcast_b_en = 1;
        set_a(2'd0, 4'd11, 1'b0, 4'd9, 32'h0B0B_000B, 32'h0);
        set_b(2'd0, 4'd12, 1'b1, 4'd1, 32'h0C0C_000C, 32'h0);
        tick("R4 swapped tags");
        idle_all();
        set_a(2'd0, 4'd13, 1'b1, 4'd1, 32'h0D0D_000D, 32'h0);
        tick("R4 enable clear");

        // R5: non-data loads and stores never write.
        idle_all(); bcast_a_en = 1; bcast_b_en = 1; simd_en = 1;
        set_a(2'd1, 4'd7, 1'b0, 4'd1, 32'hBAD0_0001, 32'hBAD0_0002);
        set_b(2'd2, 4'd10, 1'b1, 4'd9, 32'hBAD0_0003, 32'hBAD0_0004);
        tick("R5 sys load and store");
        set_a(2'd3, 4'd3, 1'b0, 4'd1, 32'hBAD0_0005, 32'h0);
        b_valid = 0;
        tick("R5 idle kind");

        // R6: SIMD fills the other lane from the second word, broadcast overrides.
        idle_all(); simd_en = 1;
        set_a(2'd0, 4'd14, 1'b1, 4'd4, 32'h6000_000E, 32'h6100_000E);
        tick("R6 simd second word");
        idle_all(); simd_en = 1; bcast_b_en = 1;
        set_b(2'd0, 4'd15, 1'b0, 4'd9, 32'h6200_000F, 32'h6300_000F);
        tick("R6 simd with broadcast");

        // R7: dual transfer, each broadcasting on its own terms.
        idle_all(); bcast_a_en = 1; bcast_b_en = 1;
        set_a(2'd0, 4'd1, 1'b1, 4'd1, 32'h7000_0001, 32'h0);
        set_b(2'd0, 4'd2, 1'b0, 4'd3, 32'h7100_0002, 32'h0);
        tick("R7 dual independent");

        // R8: same-register collisions, bus B wins.
        idle_all();
        set_a(2'd0, 4'd4, 1'b0, 4'd0, 32'h8000_0004, 32'h0);
        set_b(2'd0, 4'd4, 1'b0, 4'd0, 32'h8100_0004, 32'h0);
        tick("R8 named collision");
        idle_all(); bcast_a_en = 1;
        set_a(2'd0, 4'd6, 1'b0, 4'd1, 32'h8200_0006, 32'h0);
        set_b(2'd0, 4'd6, 1'b1, 4'd0, 32'h8300_0006, 32'h0);
        tick("R8 broadcast copy collision");

        // R9 is checked on every tick; random mix of everything.
        for (int n = 0; n < 600; n++) begin
            int r;
            bcast_a_en = 1'($urandom);
            bcast_b_en = 1'($urandom);
            simd_en    = ($urandom % 4) == 0;
            a_valid = ($urandom % 5) != 0;
            b_valid = ($urandom % 5) != 0;
            a_op = ($urandom % 2) ? 2'd0 : 2'($urandom);
            b_op = ($urandom % 2) ? 2'd0 : 2'($urandom);
            a_idx = 4'($urandom % 6); b_idx = 4'($urandom % 6);
            a_lane = 1'($urandom); b_lane = 1'($urandom);
            r = $urandom % 4;
            a_ptr = (r == 0) ? 4'd1 : (r == 1) ? 4'd9 : 4'($urandom);
            r = $urandom % 4;
            b_ptr = (r == 0) ? 4'd9 : (r == 1) ? 4'd1 : 4'($urandom);
            a_data = $urandom; a_data_y = $urandom;
            b_data = $urandom; b_data_y = $urandom;
            tick("random R7 mix");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule